// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is the transaction layer of an SMBus host controller. Software, or a local agent, fills a small byte-wide register space with the target address, the command code, any outgoing data and a byte count. It then writes a protocol code. That write launches the whole SMBus transaction. The sequencer breaks the transaction into byte-level operations: start, send byte, receive byte with ACK, receive byte with NACK, repeated start and stop. It hands them one at a time to an external byte engine, which handles bit timing on the wire.

When the transaction ends, the sequencer writes received bytes back into the data registers. It then sets a done flag together with a 5-bit result code in the status register. Packet error checking and alarm reception are not part of this block. Bit 7 of the protocol code is therefore accepted but has no effect, and the alarm locations read as zero.

Top module: `smb_host_seq`

## Requirements
- R1: Register offsets are: 0x00 protocol, 0x01 status, 0x02 target address, 0x03 command, 0x04..0x23 data bytes 0..31, 0x24 byte count. Every offset except status reads back the last value the host wrote there. Offsets 0x25..0x27 read 0 and ignore writes. Status reads {done, 0, 0, code[4:0]}.
- R2: A host write to offset 0x00 while idle starts a transaction. The same write clears done and sets the code to 0x00. Every transaction opens with a START operation and closes with a STOP operation. Acceptance of the STOP sets done.
- R3: The protocol code is decoded with bit 0 as the direction (1 = read) and bit 7 ignored. The supported codes are:
  - quick 0x02/0x03
  - byte 0x04/0x05
  - byte data 0x06/0x07
  - word data 0x08/0x09
  - block 0x0A/0x0B
  - process call 0x0C
  - block process call 0x0D
  - raw block 0x4A/0x4B
- R4: Any other code sets done with code 0x19 in the cycle after the write. No engine request is made.
- R5: The first address byte is {address register bits 7:1, direction}. Quick and byte reads send direction 1; all other protocols send 0.
- R6: If a SEND operation is answered with NAK, the next operation is STOP and the transaction ends with code 0x10.
- R7: Word data uses data byte 0 as the low byte and data byte 1 as the high byte. A process call sends both bytes and then overwrites the same two registers with the word it receives.
- R8: Block lengths are clamped to 32. A block write sends the clamped count byte before the data. A raw block write sends no count byte. A block read stores the received count, clamped, in the byte count register and receives that many bytes. A raw block read receives as many bytes as the clamped host count.
- R9: Reads with a command byte issue RSTART and then the address with bit 0 set. Every received byte is acknowledged except the last data byte, which gets NACK before STOP.
- R10: Host writes to any offset are ignored while a transaction is running.
- R11: Engine operation codes are START 0, SEND 1, RECV_ACK 2, RECV_NACK 3, RSTART 4, STOP 5. The request, operation and send byte stay stable until the engine acknowledges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_waddr | input | AW | Register write offset |
| host_wdata | input | 8 | Register write data |
| host_raddr | input | AW | Register read offset |
| host_rdata | output | 8 | Register read data (combinational) |
| eng_req | output | 1 | Operation request to the byte engine |
| eng_op | output | 3 | Operation code (R11) |
| eng_wbyte | output | 8 | Byte to send for SEND |
| eng_ack | input | 1 | One-cycle completion of the current operation |
| eng_nak | input | 1 | Target did not acknowledge the sent byte (valid with eng_ack) |
| eng_rbyte | input | 8 | Received byte (valid with eng_ack) |

## Verification
Two situations are hard to reach from the ports. The first is a block read whose received count exceeds the 32-byte limit. The second is a host write that lands while a transaction is still running. The bench's byte engine model answers each operation from a scripted queue. To reach the first case, it returns a count of 40 and then checks that exactly 32 further receive operations follow, with the last one NACKed. To reach the second, the engine model delays every acknowledge by a cycle, which holds a word write open long enough for the bench to rewrite the command and data registers in mid-flight. The bench then confirms that neither the bus traffic nor the readback changed.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        OP_START     = 3'd0,
        OP_SEND      = 3'd1,
        OP_RECV_ACK  = 3'd2,
        OP_RECV_NACK = 3'd3,
        OP_RSTART    = 3'd4,
        OP_STOP      = 3'd5
    } eng_op_e;

    typedef enum logic [1:0] {WR_NONE, WR_ONE, WR_TWO, WR_CNT} wr_kind_e;
    typedef enum logic [2:0] {RD_NONE, RD_ONE, RD_TWO, RD_HOST, RD_SLAVE} rd_kind_e;

    typedef struct packed {
        logic     valid;
        logic     addr_rd;
        logic     send_cmd;
        logic     send_cnt;
        logic     rstart;
        wr_kind_e wr;
        rd_kind_e rd;
    } proto_t;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDR1, S_CMD, S_WCNT, S_WDATA,
        S_RSTART, S_ADDR2, S_RCNT, S_RDATA, S_STOP
    } seq_st_e;

    localparam logic [4:0] RES_OK    = 5'h00;
    localparam logic [4:0] RES_NAK   = 5'h10;
    localparam logic [4:0] RES_UNSUP = 5'h19;

endpackage

// File: rtl/smb_proto_decode.sv
module smb_proto_decode
    import smb_pkg::*;
(
    input  logic [6:0] code,
    output proto_t     dec
);
    logic is_rd;

    always_comb begin
        is_rd = code[0];
        dec   = '0;
        case (code[6:1])
            6'h01: begin
                dec.valid   = 1'b1;
                dec.addr_rd = is_rd;
            end
            6'h02: begin
                dec.valid = 1'b1;
                if (is_rd) begin
                    dec.addr_rd = 1'b1;
                    dec.rd      = RD_ONE;
                end else begin
                    dec.send_cmd = 1'b1;
                end
            end
            6'h03, 6'h04: begin
                dec.valid    = 1'b1;
                dec.send_cmd = 1'b1;
                if (is_rd) begin
                    dec.rstart = 1'b1;
                    dec.rd     = (code[6:1] == 6'h03) ? RD_ONE : RD_TWO;
                end else begin
                    dec.wr = (code[6:1] == 6'h03) ? WR_ONE : WR_TWO;
                end
            end
            6'h05: begin
                dec.valid    = 1'b1;
                dec.send_cmd = 1'b1;
                if (is_rd) begin
                    dec.rstart = 1'b1;
                    dec.rd     = RD_SLAVE;
                end else begin
                    dec.send_cnt = 1'b1;
                    dec.wr       = WR_CNT;
                end
            end
            6'h06: begin
                dec.valid    = 1'b1;
                dec.send_cmd = 1'b1;
                dec.rstart   = 1'b1;
                if (is_rd) begin
                    dec.send_cnt = 1'b1;
                    dec.wr       = WR_CNT;
                    dec.rd       = RD_SLAVE;
                end else begin
                    dec.wr = WR_TWO;
                    dec.rd = RD_TWO;
                end
            end
            6'h25: begin
                dec.valid    = 1'b1;
                dec.send_cmd = 1'b1;
                if (is_rd) begin
                    dec.rstart = 1'b1;
                    dec.rd     = RD_HOST;
                end else begin
                    dec.wr = WR_CNT;
                end
            end
            default: dec = '0;
        endcase
    end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int DATA_BYTES = 32,
    parameter int AW         = 6,
    localparam int IDXW      = $clog2(DATA_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_we,
    input  logic [AW-1:0]                host_addr,
    input  logic [7:0]                   host_wdata,
    input  logic                         seq_data_we,
    input  logic [IDXW-1:0]              seq_idx,
    input  logic [7:0]                   seq_wdata,
    input  logic                         seq_cnt_we,
    input  logic [7:0]                   seq_cnt,
    output logic [7:0]                   tgt_q,
    output logic [7:0]                   cmd_q,
    output logic [7:0]                   cnt_q,
    output logic [DATA_BYTES-1:0][7:0]   data_q
);
    localparam int OFS_TGT  = 2;
    localparam int OFS_CMD  = 3;
    localparam int OFS_DATA = 4;
    localparam int OFS_CNT  = OFS_DATA + DATA_BYTES;

    typedef struct packed {
        logic [7:0]                 tgt;
        logic [7:0]                 cmd;
        logic [7:0]                 cnt;
        logic [DATA_BYTES-1:0][7:0] data;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (host_we) begin
            if (host_addr == AW'(OFS_TGT))
                r_d.tgt = host_wdata;
            else if (host_addr == AW'(OFS_CMD))
                r_d.cmd = host_wdata;
            else if (host_addr == AW'(OFS_CNT))
                r_d.cnt = host_wdata;
            else if (host_addr >= AW'(OFS_DATA) && host_addr < AW'(OFS_CNT))
                r_d.data[IDXW'(host_addr - AW'(OFS_DATA))] = host_wdata;
        end
        if (seq_data_we)
            r_d.data[seq_idx] = seq_wdata;
        if (seq_cnt_we)
            r_d.cnt = seq_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tgt_q  = r_q.tgt;
    assign cmd_q  = r_q.cmd;
    assign cnt_q  = r_q.cnt;
    assign data_q = r_q.data;
endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
    import smb_pkg::*;
#(
    parameter int DATA_BYTES = 32,
    parameter int AW         = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_waddr,
    input  logic [7:0]    host_wdata,
    input  logic [AW-1:0] host_raddr,
    output logic [7:0]    host_rdata,
    output logic          eng_req,
    output logic [2:0]    eng_op,
    output logic [7:0]    eng_wbyte,
    input  logic          eng_ack,
    input  logic          eng_nak,
    input  logic [7:0]    eng_rbyte
);
    localparam int IDXW     = $clog2(DATA_BYTES);
    localparam int LENW     = IDXW + 1;
    localparam int OFS_DATA = 4;
    localparam int OFS_CNT  = OFS_DATA + DATA_BYTES;

    typedef struct packed {
        seq_st_e         st;
        logic [7:0]      proto;
        logic            done;
        logic [4:0]      res;
        proto_t          dec;
        logic [LENW-1:0] wlen;
        logic [LENW-1:0] rlen;
        logic [LENW-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;

    logic [7:0]                 tgt_q, cmd_q, cnt_q;
    logic [DATA_BYTES-1:0][7:0] data_q;
    proto_t                     dec_in;
    logic                       idle, reg_we;
    logic                       seq_data_we, seq_cnt_we;
    logic [7:0]                 seq_cnt;
    logic [LENW-1:0]            rx_len;
    eng_op_e                    op_c;
    logic                       stat_done;

    function automatic logic [LENW-1:0] clamp_len(input logic [7:0] n);
        return (n > 8'(DATA_BYTES)) ? LENW'(DATA_BYTES) : LENW'(n);
    endfunction

    assign idle      = (s_q.st == S_IDLE);
    assign reg_we    = host_we && idle && (host_waddr != '0);
    assign rx_len    = clamp_len(eng_rbyte);
    assign seq_cnt   = 8'(rx_len);
    assign stat_done = s_q.done;

    smb_proto_decode u_dec (
        .code (host_wdata[6:0]),
        .dec  (dec_in)
    );

    smb_regfile #(.DATA_BYTES(DATA_BYTES), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we     (reg_we),
        .host_addr   (host_waddr),
        .host_wdata  (host_wdata),
        .seq_data_we (seq_data_we),
        .seq_idx     (s_q.idx[IDXW-1:0]),
        .seq_wdata   (eng_rbyte),
        .seq_cnt_we  (seq_cnt_we),
        .seq_cnt     (seq_cnt),
        .tgt_q       (tgt_q),
        .cmd_q       (cmd_q),
        .cnt_q       (cnt_q),
        .data_q      (data_q)
    );

    always_comb begin
        s_d         = s_q;
        eng_req     = 1'b0;
        op_c        = OP_START;
        eng_wbyte   = 8'h00;
        seq_data_we = 1'b0;
        seq_cnt_we  = 1'b0;
        unique case (s_q.st)
            S_IDLE: begin
                if (host_we && host_waddr == '0) begin
                    s_d.proto = host_wdata;
                    s_d.done  = 1'b0;
                    s_d.res   = RES_OK;
                    if (dec_in.valid) begin
                        s_d.dec  = dec_in;
                        s_d.idx  = '0;
                        s_d.wlen = (dec_in.wr == WR_ONE) ? LENW'(1) :
                                   (dec_in.wr == WR_TWO) ? LENW'(2) :
                                   (dec_in.wr == WR_CNT) ? clamp_len(cnt_q) : '0;
                        s_d.rlen = (dec_in.rd == RD_ONE) ? LENW'(1) :
                                   (dec_in.rd == RD_TWO) ? LENW'(2) :
                                   (dec_in.rd == RD_HOST) ? clamp_len(cnt_q) : '0;
                        s_d.st   = S_START;
                    end else begin
                        s_d.done = 1'b1;
                        s_d.res  = RES_UNSUP;
                    end
                end
            end
            S_START: begin
                eng_req = 1'b1;
                op_c    = OP_START;
                if (eng_ack) s_d.st = S_ADDR1;
            end
            S_ADDR1: begin
                eng_req   = 1'b1;
                op_c      = OP_SEND;
                eng_wbyte = {tgt_q[7:1], s_q.dec.addr_rd};
                if (eng_ack) begin
                    if (eng_nak)              begin s_d.res = RES_NAK; s_d.st = S_STOP; end
                    else if (s_q.dec.send_cmd) s_d.st = S_CMD;
                    else if (s_q.rlen != '0)   s_d.st = S_RDATA;
                    else                       s_d.st = S_STOP;
                end
            end
            S_CMD: begin
                eng_req   = 1'b1;
                op_c      = OP_SEND;
                eng_wbyte = cmd_q;
                if (eng_ack) begin
                    if (eng_nak)               begin s_d.res = RES_NAK; s_d.st = S_STOP; end
                    else if (s_q.dec.send_cnt) s_d.st = S_WCNT;
                    else if (s_q.wlen != '0)   s_d.st = S_WDATA;
                    else                       s_d.st = s_q.dec.rstart ? S_RSTART : S_STOP;
                end
            end
            S_WCNT: begin
                eng_req   = 1'b1;
                op_c      = OP_SEND;
                eng_wbyte = 8'(s_q.wlen);
                if (eng_ack) begin
                    if (eng_nak)             begin s_d.res = RES_NAK; s_d.st = S_STOP; end
                    else if (s_q.wlen != '0) s_d.st = S_WDATA;
                    else                     s_d.st = s_q.dec.rstart ? S_RSTART : S_STOP;
                end
            end
            S_WDATA: begin
                eng_req   = 1'b1;
                op_c      = OP_SEND;
                eng_wbyte = data_q[s_q.idx[IDXW-1:0]];
                if (eng_ack) begin
                    if (eng_nak) begin
                        s_d.res = RES_NAK;
                        s_d.st  = S_STOP;
                    end else if (s_q.idx == s_q.wlen - 1'b1) begin
                        s_d.idx = '0;
                        s_d.st  = s_q.dec.rstart ? S_RSTART : S_STOP;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            S_RSTART: begin
                eng_req = 1'b1;
                op_c    = OP_RSTART;
                if (eng_ack) s_d.st = S_ADDR2;
            end
            S_ADDR2: begin
                eng_req   = 1'b1;
                op_c      = OP_SEND;
                eng_wbyte = {tgt_q[7:1], 1'b1};
                if (eng_ack) begin
                    if (eng_nak)                   begin s_d.res = RES_NAK; s_d.st = S_STOP; end
                    else if (s_q.dec.rd == RD_SLAVE) s_d.st = S_RCNT;
                    else if (s_q.rlen != '0)       s_d.st = S_RDATA;
                    else                           s_d.st = S_STOP;
                end
            end
            S_RCNT: begin
                eng_req = 1'b1;
                op_c    = OP_RECV_ACK;
                if (eng_ack) begin
                    seq_cnt_we = 1'b1;
                    s_d.rlen   = rx_len;
                    s_d.st     = (rx_len != '0) ? S_RDATA : S_STOP;
                end
            end
            S_RDATA: begin
                eng_req = 1'b1;
                op_c    = (s_q.idx == s_q.rlen - 1'b1) ? OP_RECV_NACK : OP_RECV_ACK;
                if (eng_ack) begin
                    seq_data_we = 1'b1;
                    if (s_q.idx == s_q.rlen - 1'b1) s_d.st = S_STOP;
                    else                            s_d.idx = s_q.idx + 1'b1;
                end
            end
            S_STOP: begin
                eng_req = 1'b1;
                op_c    = OP_STOP;
                if (eng_ack) begin
                    s_d.done = 1'b1;
                    s_d.st   = S_IDLE;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: S_IDLE, dec: '0, default: '0};
        else        s_q <= s_d;
    end

    assign eng_op = op_c;

    always_comb begin
        host_rdata = 8'h00;
        if (host_raddr == AW'(0))
            host_rdata = s_q.proto;
        else if (host_raddr == AW'(1))
            host_rdata = {s_q.done, 2'b00, s_q.res};
        else if (host_raddr == AW'(2))
            host_rdata = tgt_q;
        else if (host_raddr == AW'(3))
            host_rdata = cmd_q;
        else if (host_raddr == AW'(OFS_CNT))
            host_rdata = cnt_q;
        else if (host_raddr >= AW'(OFS_DATA) && host_raddr < AW'(OFS_CNT))
            host_rdata = data_q[IDXW'(host_raddr - AW'(OFS_DATA))];
    end
endmodule

// File: rtl/smb_host_seq_chk.sv
module smb_host_seq_chk
    import smb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       eng_req,
    input logic       eng_ack,
    input logic       eng_nak,
    input logic [2:0] eng_op,
    input logic [7:0] eng_wbyte,
    input logic       stat_done
);
    // R11: request and payload held until acknowledged
    p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op) && $stable(eng_wbyte)));

    // R2: a transaction always opens with START
    p_open_with_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req) |-> (eng_op == 3'(OP_START)));

    // R2: acceptance of STOP raises done
    p_done_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_ack && eng_op == 3'(OP_STOP)) |=> stat_done);

    // R6: a NAK on a sent byte is followed by STOP
    p_stop_after_nak_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_ack && eng_nak && eng_op == 3'(OP_SEND)) |=>
        (eng_req && eng_op == 3'(OP_STOP)));

    // R4: no engine activity while done is reported
    p_quiet_when_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |-> !eng_req);
endmodule

bind smb_host_seq smb_host_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_req   (eng_req),
    .eng_ack   (eng_ack),
    .eng_nak   (eng_nak),
    .eng_op    (eng_op),
    .eng_wbyte (eng_wbyte),
    .stat_done (stat_done)
);

// File: tb/smb_host_seq_tb.sv
module smb_host_seq_tb;
    import smb_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [5:0] host_waddr = '0;
    logic [7:0] host_wdata = '0;
    logic [5:0] host_raddr = '0;
    logic [7:0] host_rdata;
    logic       eng_req;
    logic [2:0] eng_op;
    logic [7:0] eng_wbyte;
    logic       eng_ack = 1'b0;
    logic       eng_nak = 1'b0;
    logic [7:0] eng_rbyte = '0;

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R2";

    typedef struct {
        logic [2:0] op;
        logic [7:0] b;
        logic       nak;
        logic [7:0] rx;
    } exp_t;
    exp_t expq[$];

    always #5 clk = ~clk;

    smb_host_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
        .eng_ack(eng_ack), .eng_nak(eng_nak), .eng_rbyte(eng_rbyte)
    );

    // Monitor / engine model: pops expected operations and answers them
    initial begin
        forever begin
            @(negedge clk);
            if (eng_req) begin
                exp_t e;
                tests++;
                if (expq.size() == 0) begin
                    fails++;
                    $display("FAIL %s: unexpected op %0d byte %02h, expected none", cur_req, eng_op, eng_wbyte);
                    e = '{op: eng_op, b: 8'h00, nak: 1'b0, rx: 8'h00};
                end else begin
                    e = expq.pop_front();
                    if (eng_op !== e.op || (e.op == 3'(OP_SEND) && eng_wbyte !== e.b)) begin
                        fails++;
                        $display("FAIL %s: op %0d byte %02h, expected op %0d byte %02h",
                                 cur_req, eng_op, eng_wbyte, e.op, e.b);
                    end
                end
                @(negedge clk);
                eng_ack   = 1'b1;
                eng_nak   = e.nak;
                eng_rbyte = e.rx;
                @(negedge clk);
                eng_ack = 1'b0;
                eng_nak = 1'b0;
            end
        end
    end

    task automatic ex(input eng_op_e op, input logic [7:0] b, input logic nak, input logic [7:0] rx);
        expq.push_back('{op: 3'(op), b: b, nak: nak, rx: rx});
    endtask

    task automatic hw(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic chk(input logic [5:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        host_raddr = a;
        #1;
        tests++;
        if (host_rdata !== exp) begin
            fails++;
            $display("FAIL %s: reg %02h read %02h, expected %02h", req, a, host_rdata, exp);
        end
    endtask

    task automatic wait_done(input string req);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            host_raddr = 6'h01;
            #1;
            if (host_rdata[7]) break;
        end
        tests++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d ops left, expected 0", req, expq.size());
            expq.delete();
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1/R2: reset state
        chk(6'h01, 8'h00, "R2");
        chk(6'h00, 8'h00, "R1");

        // R1: register readback and unused offsets
        hw(6'h02, 8'hA0); hw(6'h03, 8'h33); hw(6'h04, 8'h11); hw(6'h23, 8'h99);
        hw(6'h24, 8'h05); hw(6'h25, 8'h77);
        chk(6'h02, 8'hA0, "R1"); chk(6'h03, 8'h33, "R1"); chk(6'h04, 8'h11, "R1");
        chk(6'h23, 8'h99, "R1"); chk(6'h24, 8'h05, "R1"); chk(6'h25, 8'h00, "R1");

        // R3/R5: quick write with PEC bit set (ignored)
        cur_req = "R3";
        ex(OP_START, 0, 0, 0); ex(OP_SEND, 8'hA0, 0, 0); ex(OP_STOP, 0, 0, 0);
        hw(6'h00, 8'h82);
        wait_done("R3");
        chk(6'h01, 8'h80, "R3");

        // R5: byte read uses read bit in first address
        cur_req = "R5";
        ex(OP_START, 0, 0, 0); ex(OP_SEND, 8'hA1, 0, 0); ex(OP_RECV_NACK, 0, 0, 8'h6C); ex(OP_STOP, 0, 0, 0);
        hw(6'h00, 8'h05);
        wait_done("R5");
        chk(6'h04, 8'h6C, "R5");

        // R9: byte data read with repeated start
        cur_req = "R9";
        hw(6'h03, 8'h10);
        ex(OP_START, 0, 0, 0); ex(OP_SEND, 8'hA0, 0, 0); ex(OP_SEND, 8'h10, 0, 0);
        ex(OP_RSTART, 0, 0, 0); ex(OP_SEND, 8'hA1, 0, 0); ex(OP_RECV_NACK, 0, 0, 8'h5A); ex(OP_STOP, 0, 0, 0);
        hw(6'h00, 8'h07);
        wait_done("R9");
        chk(6'h04, 8'h5A, "R9");

        // R7/R10/R2: word write, done cleared at start, writes while busy ignored
        cur_req = "R7";
        hw(6'h03, 8'h21); hw(6'h04, 8'h34); hw(6'h05, 8'h12);
        ex(OP_START, 0, 0, 0); ex(OP_SEND, 8'hA0, 0, 0); ex(OP_SEND, 8'h21, 0, 0);
        ex(OP_SEND, 8'h34, 0, 0); ex(OP_SEND, 8'h12, 0, 0); ex(OP_STOP, 0, 0, 0);
        hw(6'h00, 8'h08);
        chk(6'h01, 8'h00, "R2");
        hw(6'h03, 8'h55); hw(6'h04, 8'hEE);
        wait_done("R7");
        chk(6'h03, 8'h21, "R10"); chk(6'h04, 8'h34, "R10"); chk(6'h00, 8'h08, "R10");

        // R7: process call reads back into data 0/1
        ex(OP_START, 0, 0, 0); ex(OP_SEND, 8'hA0, 0, 0); ex(OP_SEND, 8'h21, 0, 0);
        ex(OP_SEND, 8'h34, 0, 0); ex(OP_SEND, 8'h12, 0, 0); ex(OP_RSTART, 0, 0, 0);
        ex(OP_SEND, 8'hA1, 0, 0); ex(OP_RECV_ACK, 0, 0, 8'hCD); ex(OP_RECV_NACK, 0, 0, 8'hAB); ex(OP_STOP, 0, 0, 0);
        hw(6'h00, 8'h0C);
        wait_done("R7");
        chk(6'h04, 8'hCD, "R7"); chk(6'h05, 8'hAB, "R7");

        // R8: block write with count 40 clamped to 32
        cur_req = "R8";
        for (int i = 0; i < 32; i++) hw(6'(4 + i), 8'(8'h40 + i));
        hw(6'h24, 8'd40);
        ex(OP_START, 0, 0, 0); ex(OP_SEND, 8'hA0, 0, 0); ex(OP_SEND, 8'h21, 0, 0); ex(OP_SEND, 8'h20, 0, 0);
        for (int i = 0; i < 32; i++) ex(OP_SEND, 8'(8'h40 + i), 0, 0);
        ex(OP_STOP, 0, 0, 0);
        hw(6'h00, 8'h0A);
        wait_done("R8");
        chk(6'h01, 8'h80, "R8");

        // R8/R9: block read, slave count 3
        ex(OP_START, 0, 0, 0); ex(OP_SEND, 8'hA0, 0, 0); ex(OP_SEND, 8'h21, 0, 0);
        ex(OP_RSTART, 0, 0, 0); ex(OP_SEND, 8'hA1, 0, 0); ex(OP_RECV_ACK, 0, 0, 8'd3);
        ex(OP_RECV_ACK, 0, 0, 8'hD0); ex(OP_RECV_ACK, 0, 0, 8'hD1); ex(OP_RECV_NACK, 0, 0, 8'hD2); ex(OP_STOP, 0, 0, 0);
        hw(6'h00, 8'h0B);
        wait_done("R8");
        chk(6'h24, 8'd3, "R8"); chk(6'h06, 8'hD2, "R8");

        // R8: block read, slave count 40 clamped to 32
        ex(OP_START, 0, 0, 0); ex(OP_SEND, 8'hA0, 0, 0); ex(OP_SEND, 8'h21, 0, 0);
        ex(OP_RSTART, 0, 0, 0); ex(OP_SEND, 8'hA1, 0, 0); ex(OP_RECV_ACK, 0, 0, 8'd40);
        for (int i = 0; i < 31; i++) ex(OP_RECV_ACK, 0, 0, 8'(8'h80 + i));
        ex(OP_RECV_NACK, 0, 0, 8'h9F); ex(OP_STOP, 0, 0, 0);
        hw(6'h00, 8'h0B);
        wait_done("R8");
        chk(6'h24, 8'd32, "R8"); chk(6'h23, 8'h9F, "R8");

        // R8: raw block read uses host count 2, no count byte
        hw(6'h24, 8'd2);
        ex(OP_START, 0, 0, 0); ex(OP_SEND, 8'hA0, 0, 0); ex(OP_SEND, 8'h21, 0, 0);
        ex(OP_RSTART, 0, 0, 0); ex(OP_SEND, 8'hA1, 0, 0);
        ex(OP_RECV_ACK, 0, 0, 8'hE0); ex(OP_RECV_NACK, 0, 0, 8'hE1); ex(OP_STOP, 0, 0, 0);
        hw(6'h00, 8'h4B);
        wait_done("R8");
        chk(6'h24, 8'd2, "R8"); chk(6'h05, 8'hE1, "R8");

        // R6: NAK on command byte
        cur_req = "R6";
        ex(OP_START, 0, 0, 0); ex(OP_SEND, 8'hA0, 0, 0); ex(OP_SEND, 8'h21, 1, 0); ex(OP_STOP, 0, 0, 0);
        hw(6'h00, 8'h08);
        wait_done("R6");
        chk(6'h01, 8'h90, "R6");

        // R4: unsupported codes, no bus activity
        cur_req = "R4";
        hw(6'h00, 8'h10);
        chk(6'h01, 8'h99, "R4");
        hw(6'h00, 8'h0E);
        repeat (20) @(negedge clk);
        chk(6'h01, 8'h99, "R4");
        tests++;
        if (eng_req !== 1'b0) begin
            fails++;
            $display("FAIL R4: eng_req %b, expected 0", eng_req);
        end

        repeat (5) @(negedge clk);
        summary();
    end
endmodule